// File: doc/BRIEF.md
# Serial ADC Host Reader

This block is the host end of a four-wire link to an 8-bit serial analogue-to-digital converter. A request names an input channel through a single/differential bit, an odd/even bit and a group of select bits. When the request is accepted, the block pulls chip select low and generates the serial clock by dividing the system clock. It shifts a start bit and the channel address out on the data line, then releases that line so the converter can drive it. The converter returns its result twice: first most-significant bit first, then least-significant bit first. The block collects both copies and compares them.

Once the frame ends, the block raises chip select and returns the MSB-first copy as the result. The result comes with a one-cycle valid strobe and two flags. One flag reports that the two copies disagree. The other reports that the converter's busy status did not match the phase of the frame. The block then keeps chip select high for a minimum time before it accepts the next request. A request that arrives while a frame is running waits, held off by the ready signal.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, and whenever no frame is running, chip select is high, the serial clock is low, the data-line drive enable is low, ready is high and result valid is low.
- R2: A request is accepted on a clock edge where request valid and ready are both high. Ready falls on that edge and stays low until the chip-select gap of R10 has passed. A request held high during a frame is not accepted and does not change the frame.
- R3: The bits on the data line are sent one per serial-clock period, in this order: 1 (start), single/differential, odd/even, then the select bits most significant first. Each bit changes only at the start of a low phase and is stable across the following rising edge.
- R4: Each serial-clock period has a low phase followed by a high phase, each HALF_DIV system cycles long. Chip select stays low for exactly ADDR_W+17 periods, where ADDR_W = 3 + SEL_W. The clock idles low whenever chip select is high.
- R5: The drive enable for the data line is high only during the first ADDR_W periods of a frame. For the rest of the frame the converter owns the line.
- R6: The line is sampled at the end of each high phase. The sample in period ADDR_W is a null bit and is ignored. The samples in periods ADDR_W+1 to ADDR_W+8 form the result, most significant bit first.
- R7: The samples in periods ADDR_W+9 to ADDR_W+16 are the same result least significant bit first. The mismatch flag is set when this copy, reversed, differs from the MSB-first copy.
- R8: The sequence-error flag is set if the converter status input is low at any MSB-first sample, or high at any LSB-first sample.
- R9: Result valid is a one-cycle pulse one system cycle after chip select rises. The data, mismatch flag and sequence-error flag are valid with it.
- R10: Once chip select rises, it stays high for at least CS_GAP system cycles. Ready returns exactly CS_GAP cycles after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Conversion request |
| req_ready_o | output | 1 | Block can accept a request |
| req_single_i | input | 1 | Single-ended (1) or differential (0) address bit |
| req_odd_i | input | 1 | Odd/even address bit |
| req_sel_i | input | SEL_W | Channel select bits, sent MSB first |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| dio_o | output | 1 | Data bit driven toward the converter |
| dio_oe_o | output | 1 | Drive enable for the shared data line |
| dio_i | input | 1 | Data line as seen at the host |
| sars_i | input | 1 | Converter busy status |
| res_valid_o | output | 1 | Result strobe |
| res_data_o | output | 8 | Converted value (MSB-first copy) |
| res_mismatch_o | output | 1 | The two result copies disagree |
| res_seq_err_o | output | 1 | The busy status did not follow the frame phases |

## Verification
The result values include all zeros, all ones, alternating bits and single set bits at either end. These patterns show whether a bit order is reversed or shifted by one in either copy, and whether the null bit is taken in by mistake. Addresses cover both modes and every select value, and a model of the converter checks the bits it latches. One frame corrupts a single bit of the LSB-first copy, which should raise only the mismatch flag. Another holds the status low, which should raise only the sequence flag. Requests held through a busy frame and a back-to-back pair check that ready returns at exactly the cycle the chip-select gap ends.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
    localparam int unsigned RES_W    = 8;
    localparam int unsigned HDR_BITS = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_GAP   = 2'd2
    } rd_state_e;
endpackage

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen #(
    parameter int unsigned HALF_DIV = 42
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
    } gen_t;

    gen_t gen_d, gen_q;
    logic term;

    always_comb begin
        gen_d = gen_q;
        term  = run_i && (gen_q.cnt == LAST);
        if (!run_i) begin
            gen_d.cnt = '0;
            gen_d.ph  = 1'b0;
        end else if (term) begin
            gen_d.cnt = '0;
            gen_d.ph  = ~gen_q.ph;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gen_q <= '0;
        else         gen_q <= gen_d;
    end

    assign sclk_o = gen_q.ph;
    assign rise_o = term && !gen_q.ph;
    assign fall_o = term && gen_q.ph;

    // phase length observer
    logic [CW:0] plen_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             plen_q <= '0;
        else if (!run_i || (gen_d.ph != gen_q.ph)) plen_q <= '0;
        else                                     plen_q <= plen_q + 1'b1;
    end

    // R4
    half_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && (gen_d.ph != gen_q.ph)) |-> (plen_q == (CW+1)'(HALF_DIV - 1)));
endmodule

// File: rtl/adcrd_sync.sv
module adcrd_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    logic [STAGES-1:0][W-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = din_i;
        for (int i = 1; i < STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign dout_o = sync_q[STAGES-1];
endmodule

// File: rtl/adcrd_capture.sv
module adcrd_capture
    import adcrd_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned PW     = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             fall_i,
    input  logic [PW-1:0]    period_i,
    input  logic             do_s_i,
    input  logic             sars_s_i,
    output logic [RES_W-1:0] msb_o,
    output logic [RES_W-1:0] lsb_o,
    output logic             seq_err_o
);
    localparam logic [PW-1:0] MSB_LO = PW'(ADDR_W + 1);
    localparam logic [PW-1:0] MSB_HI = PW'(ADDR_W + RES_W);
    localparam logic [PW-1:0] LSB_LO = PW'(ADDR_W + RES_W + 1);
    localparam logic [PW-1:0] LSB_HI = PW'(ADDR_W + 2*RES_W);

    typedef struct packed {
        logic [RES_W-1:0] msb;
        logic [RES_W-1:0] lsb;
        logic             err;
    } cap_t;

    cap_t cap_d, cap_q;
    logic in_msb, in_lsb;

    always_comb begin
        cap_d  = cap_q;
        in_msb = (period_i >= MSB_LO) && (period_i <= MSB_HI);
        in_lsb = (period_i >= LSB_LO) && (period_i <= LSB_HI);
        if (clear_i) begin
            cap_d = '0;
        end else if (fall_i) begin
            if (in_msb) begin
                cap_d.msb = {cap_q.msb[RES_W-2:0], do_s_i};
                if (!sars_s_i) cap_d.err = 1'b1;
            end
            if (in_lsb) begin
                cap_d.lsb = {do_s_i, cap_q.lsb[RES_W-1:1]};
                if (sars_s_i) cap_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
    end

    assign msb_o     = cap_q.msb;
    assign lsb_o     = cap_q.lsb;
    assign seq_err_o = cap_q.err;

    // R8
    seq_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_err_o && !clear_i) |=> seq_err_o);

    // R7
    copies_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fall_i && !clear_i) |=> ($stable(msb_o) && $stable(lsb_o)));
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
    import adcrd_pkg::*;
#(
    parameter int unsigned HALF_DIV = 42,
    parameter int unsigned CS_GAP   = 12,
    parameter int unsigned SEL_W    = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic             req_single_i,
    input  logic             req_odd_i,
    input  logic [SEL_W-1:0] req_sel_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             dio_o,
    output logic             dio_oe_o,
    input  logic             dio_i,
    input  logic             sars_i,
    output logic             res_valid_o,
    output logic [RES_W-1:0] res_data_o,
    output logic             res_mismatch_o,
    output logic             res_seq_err_o
);
    localparam int unsigned ADDR_W  = HDR_BITS + SEL_W;
    localparam int unsigned FRAME_P = ADDR_W + 2*RES_W + 1;
    localparam int unsigned PW      = $clog2(FRAME_P + 1);
    localparam int unsigned GW      = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
    localparam logic [PW-1:0] LAST_P = PW'(FRAME_P - 1);
    localparam logic [GW-1:0] LAST_G = GW'(CS_GAP - 1);

    typedef struct packed {
        rd_state_e         state;
        logic [PW-1:0]     period;
        logic [GW-1:0]     gap;
        logic [ADDR_W-1:0] addr;
        logic              cs_n;
        logic              di;
        logic              oe;
        logic              valid;
        logic [RES_W-1:0]  data;
        logic              mism;
        logic              seqe;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             rise, fall, accept;
    logic [1:0]       sync_out;
    logic [RES_W-1:0] msb_word, lsb_word;
    logic             seq_err;
    logic [PW-1:0]    nxt_period;

    adcrd_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (ctl_q.state == ST_FRAME),
        .sclk_o (sclk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    adcrd_sync #(.W(2), .STAGES(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  ({dio_i, sars_i}),
        .dout_o (sync_out)
    );

    assign accept = (ctl_q.state == ST_IDLE) && req_valid_i;

    adcrd_capture #(.ADDR_W(ADDR_W), .PW(PW)) u_cap (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (accept),
        .fall_i    (fall),
        .period_i  (ctl_q.period),
        .do_s_i    (sync_out[1]),
        .sars_s_i  (sync_out[0]),
        .msb_o     (msb_word),
        .lsb_o     (lsb_word),
        .seq_err_o (seq_err)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        nxt_period  = ctl_q.period + 1'b1;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    ctl_d.state  = ST_FRAME;
                    ctl_d.period = '0;
                    ctl_d.addr   = {1'b1, req_single_i, req_odd_i, req_sel_i};
                    ctl_d.cs_n   = 1'b0;
                    ctl_d.di     = 1'b1;
                    ctl_d.oe     = 1'b1;
                end
            end
            ST_FRAME: begin
                if (fall) begin
                    if (ctl_q.period == LAST_P) begin
                        ctl_d.state = ST_GAP;
                        ctl_d.gap   = '0;
                        ctl_d.cs_n  = 1'b1;
                        ctl_d.oe    = 1'b0;
                        ctl_d.di    = 1'b0;
                    end else begin
                        ctl_d.period = nxt_period;
                        ctl_d.addr   = ctl_q.addr << 1;
                        if (nxt_period < PW'(ADDR_W)) begin
                            ctl_d.di = ctl_q.addr[ADDR_W-2];
                            ctl_d.oe = 1'b1;
                        end else begin
                            ctl_d.di = 1'b0;
                            ctl_d.oe = 1'b0;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (ctl_q.gap == '0) begin
                    ctl_d.valid = 1'b1;
                    ctl_d.data  = msb_word;
                    ctl_d.mism  = (msb_word != lsb_word);
                    ctl_d.seqe  = seq_err;
                end
                if (ctl_q.gap == LAST_G) ctl_d.state = ST_IDLE;
                else                     ctl_d.gap   = ctl_q.gap + 1'b1;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q.state  <= ST_IDLE;
            ctl_q.period <= '0;
            ctl_q.gap    <= '0;
            ctl_q.addr   <= '0;
            ctl_q.cs_n   <= 1'b1;
            ctl_q.di     <= 1'b0;
            ctl_q.oe     <= 1'b0;
            ctl_q.valid  <= 1'b0;
            ctl_q.data   <= '0;
            ctl_q.mism   <= 1'b0;
            ctl_q.seqe   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready_o    = (ctl_q.state == ST_IDLE);
    assign cs_n_o         = ctl_q.cs_n;
    assign dio_o          = ctl_q.di;
    assign dio_oe_o       = ctl_q.oe;
    assign res_valid_o    = ctl_q.valid;
    assign res_data_o     = ctl_q.data;
    assign res_mismatch_o = ctl_q.mism;
    assign res_seq_err_o  = ctl_q.seqe;

    // chip-select high-time observer
    logic [GW:0] csh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          csh_q <= (GW+1)'(CS_GAP);
        else if (!cs_n_o)                     csh_q <= '0;
        else if (csh_q != (GW+1)'(CS_GAP))    csh_q <= csh_q + 1'b1;
    end

    // R5
    oe_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dio_oe_o |-> !cs_n_o);

    // R4
    sclk_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_n_o |-> !sclk_o);

    // R9
    valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |=> !res_valid_o);

    // R9
    valid_cs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |-> cs_n_o);

    // R2
    ready_cs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> (cs_n_o && !sclk_o));

    // R10
    cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cs_n_o) |-> (csh_q >= (GW+1)'(CS_GAP)));
endmodule

// File: tb/adc_serial_reader_tb_top.sv
module adc_serial_reader_tb_top;
    localparam int H  = 42;
    localparam int G  = 12;
    localparam int SW = 2;
    localparam int A  = 3 + SW;
    localparam int P  = A + 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          req_valid = 1'b0, req_single = 1'b0, req_odd = 1'b0;
    logic [SW-1:0] req_sel = '0;
    logic          req_ready, cs_n, sclk, dio, dio_oe, dio_in, sars_in;
    logic          res_valid, res_mism, res_seqe;
    logic [7:0]    res_data;

    // converter model state
    logic          dev_do = 1'b0, dev_sars = 1'b0, sprev = 1'b0;
    int            rc = 0;
    logic [A-1:0]  dev_addr = '0;

    // bench reference state
    int            m_st = 0, m_k = 0, m_g = 0;
    logic [A-1:0]  m_addr = '0;
    logic [7:0]    pend_val = '0, cur_val = '0;
    bit            pend_flip = 0, pend_drop = 0, cur_flip = 0, cur_drop = 0;
    int            n_chk = 0, n_fail = 0, n_results = 0;

    assign dio_in  = dio_oe ? dio : dev_do;
    assign sars_in = dev_sars && !cur_drop;

    adc_serial_reader #(.HALF_DIV(H), .CS_GAP(G), .SEL_W(SW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_single_i(req_single), .req_odd_i(req_odd), .req_sel_i(req_sel),
        .cs_n_o(cs_n), .sclk_o(sclk), .dio_o(dio), .dio_oe_o(dio_oe),
        .dio_i(dio_in), .sars_i(sars_in),
        .res_valid_o(res_valid), .res_data_o(res_data),
        .res_mismatch_o(res_mism), .res_seq_err_o(res_seqe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // converter model: reacts to host outputs away from the system edge
    always @(negedge clk) begin
        if (cs_n) begin
            rc = 0; dev_do = 1'b0; dev_sars = 1'b0; sprev = 1'b0;
        end else begin
            if (sclk && !sprev) begin
                if (rc < A) dev_addr = {dev_addr[A-2:0], dio_in};
                rc++;
            end else if (!sclk && sprev) begin
                if (rc == A) begin
                    dev_sars = 1'b1; dev_do = 1'b0;
                end else if (rc >= A+1 && rc <= A+8) begin
                    dev_do = cur_val[7-(rc-A-1)];
                end else if (rc >= A+9 && rc <= A+16) begin
                    dev_sars = 1'b0;
                    dev_do = (cur_val ^ (cur_flip ? 8'h10 : 8'h00)) >> (rc-A-9);
                end else begin
                    dev_do = 1'b0;
                end
            end
            sprev = sclk;
        end
    end

    // reference sequence, advanced on each system edge
    always @(posedge clk) begin
        if (rst_n) begin
            case (m_st)
                0: if (req_valid) begin
                    m_st = 1; m_k = 0;
                    m_addr = {1'b1, req_single, req_odd, req_sel};
                    cur_val = pend_val; cur_flip = pend_flip; cur_drop = pend_drop;
                end
                1: begin
                    m_k++;
                    if (m_k == 2*H*P) begin m_st = 2; m_g = 0; end
                end
                default: begin
                    m_g++;
                    if (m_g == G) m_st = 0;
                end
            endcase
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_cs, e_sclk, e_oe, e_di, e_rdy, e_val;
            int pi;
            e_cs = 1; e_sclk = 0; e_oe = 0; e_di = 0; e_rdy = 0; e_val = 0;
            if (m_st == 0) begin
                e_rdy = 1;
            end else if (m_st == 1) begin
                e_cs = 0;
                e_sclk = ((m_k / H) % 2) == 1;
                pi = m_k / (2*H);
                e_oe = (pi < A);
                if (e_oe) e_di = m_addr[A-1-pi];
            end else begin
                e_val = (m_g == 1);
            end
            chk(cs_n == e_cs && sclk == e_sclk, "R4 cs_n/sclk", {cs_n, sclk}, {e_cs, e_sclk});
            chk(dio_oe == e_oe, "R5 drive enable", dio_oe, e_oe);
            if (e_oe) chk(dio == e_di, "R3 address bit", dio, e_di);
            chk(req_ready == e_rdy, "R2/R10 ready", req_ready, e_rdy);
            chk(res_valid == e_val, "R9 result valid", res_valid, e_val);
            if (e_val) begin
                n_results++;
                chk(res_data == cur_val, "R6 MSB-first result", res_data, cur_val);
                chk(res_mism == cur_flip, "R7 mismatch flag", res_mism, cur_flip);
                chk(res_seqe == cur_drop, "R8 status sequence flag", res_seqe, cur_drop);
                chk(dev_addr == m_addr, "R3 address latched by converter", dev_addr, m_addr);
            end
        end
    end

    task automatic do_req(input bit s, input bit o, input logic [SW-1:0] sel,
                          input logic [7:0] v, input bit fl, input bit dr);
        @(negedge clk);
        req_single = s; req_odd = o; req_sel = sel;
        pend_val = v; pend_flip = fl; pend_drop = dr;
        req_valid = 1'b1;
        do @(negedge clk); while (m_st != 1);
        req_valid = 1'b0;
        do @(negedge clk); while (m_st != 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(0, "R2 watchdog expired", 0, 1);
        wrap_up();
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1 reset state while reset is held
        chk(cs_n && !sclk && !dio_oe && req_ready && !res_valid, "R1 reset outputs",
            {cs_n, sclk, dio_oe, req_ready, res_valid}, 5'b10010);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(cs_n && !sclk && !dio_oe && req_ready && !res_valid, "R1 idle outputs",
            {cs_n, sclk, dio_oe, req_ready, res_valid}, 5'b10010);

        // R6 bit-order patterns over both modes and all selects
        do_req(1, 0, 2'd0, 8'h00, 0, 0);
        do_req(1, 1, 2'd3, 8'hFF, 0, 0);
        do_req(0, 1, 2'd1, 8'hA5, 0, 0);
        do_req(0, 0, 2'd2, 8'h01, 0, 0);
        do_req(1, 0, 2'd1, 8'h80, 0, 0);
        // R7 corrupted LSB-first copy
        do_req(1, 1, 2'd2, 8'h3C, 1, 0);
        // R8 status never rises
        do_req(0, 0, 2'd3, 8'h5A, 0, 1);

        // R2 request raised during a frame is held off
        @(negedge clk);
        req_single = 1; req_odd = 0; req_sel = 2'd2;
        pend_val = 8'h69; pend_flip = 0; pend_drop = 0;
        req_valid = 1'b1;
        do @(negedge clk); while (m_st != 1);
        req_valid = 1'b0;
        repeat (300) @(negedge clk);
        req_single = 0; req_odd = 1; req_sel = 2'd0;
        req_valid = 1'b1;
        repeat (400) @(negedge clk);
        req_valid = 1'b0;
        chk(m_st == 1 && !cs_n, "R2 frame undisturbed by busy request", cs_n, 0);
        do @(negedge clk); while (m_st != 0);

        // R10 back-to-back: second request waits exactly for the gap
        @(negedge clk);
        req_single = 0; req_odd = 1; req_sel = 2'd3;
        pend_val = 8'hC3; pend_flip = 0; pend_drop = 0;
        req_valid = 1'b1;
        do @(negedge clk); while (m_st != 1);
        req_single = 1; req_odd = 1; req_sel = 2'd1;
        pend_val = 8'h7E;
        do @(negedge clk); while (m_st != 2);
        do @(negedge clk); while (m_st != 1);
        req_valid = 1'b0;
        do @(negedge clk); while (m_st != 0);

        repeat (5) @(negedge clk);
        chk(n_results == 10, "R9 result count", n_results, 10);
        wrap_up();
    end
endmodule